// File: doc/BRIEF.md
# Threshold-Driven Thermal Throttle Controller

This block reads one unsigned temperature value per functional unit and, once per fixed sampling window, decides how the chip should be throttled. A two-bit policy input picks one of four responses: stop the global clock, disable the fetch input of one pipeline stage, put the whole chip into a reduced voltage/frequency mode, or put only the overheated units into that reduced mode. A unit is hot when its reading is strictly above a programmable threshold. The threshold resets to 97 degrees, which is a 100 degree safe limit less a 3 degree sensor tolerance.

Decisions are registered only on the clock edge that closes a sampling window, so every response lasts a whole number of windows. Each change of scaling state, whether chip-wide or for a single unit, raises a chip-wide resynchronization stall for a fixed number of cycles. A scaling change that comes due while a stall is still running is not applied. It is taken up again at the first window boundary after the stall has ended. Two saturating counters report the cycles spent throttled and the cycles spent stalled.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: During and just after reset, clk_en is 1, fetch_en is all ones, chip_scale and unit_scale are 0, resync_stall is 0, both cycle counters are 0, and the threshold is DEFAULT_THRESH (97).
- R2: Boundaries fall on every SAMPLE_PERIOD-th clock edge after reset is released. clk_en, fetch_en, chip_scale and unit_scale change only on a boundary edge, using the temperatures and configuration present at that edge.
- R3: A unit is hot only when its reading is strictly greater than the threshold, so a reading equal to the threshold is not hot. A one-cycle thresh_wr pulse loads thresh_wdata, and the new value applies from the next boundary.
- R4: With policy_sel = 0 (clock gating), clk_en goes to 0 after a boundary where any unit is hot, and returns to 1 only after a boundary where no unit is hot. Under any other policy, clk_en is 1 after every boundary.
- R5: With policy_sel = 1 (fetch gating), the fetch_en bit picked by fetch_stage_sel (0 = vertex fetch, bit 0; 1 = rasterizer, bit 1) goes to 0 after a boundary where any unit is hot. The other stage and clk_en stay at 1.
- R6: With policy_sel = 2 (chip-wide scaling), the target for chip_scale is 1 when any unit is hot and 0 otherwise. unit_scale stays 0.
- R7: With policy_sel = 3 (per-unit scaling), the target for unit_scale[i] is the hot state of unit i. chip_scale stays 0, and chip_scale and any unit_scale bit are never 1 together.
- R8: Every change of chip_scale or of any unit_scale bit raises resync_stall in the same cycle, and resync_stall stays at 1 for exactly RESYNC_CYCLES cycles.
- R9: When a boundary finds a stall still running, chip_scale and unit_scale keep their values. The pending change is applied at the first boundary after the stall has ended, and it starts a new stall there.
- R10: Moving away from a scaling policy returns the scale flags to 0 at a boundary, and that return goes through the same stall rule as any other scaling change.
- R11: throttle_cycles counts the cycles in which clk_en is 0, or any fetch_en bit is 0, or any scale flag is 1. stall_cycles counts the cycles in which resync_stall is 1. Both counters saturate at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_sel | input | 2 | 0 clock gating, 1 fetch gating, 2 chip-wide scaling, 3 per-unit scaling |
| fetch_stage_sel | input | $clog2(N_STAGES) | Stage whose fetch is gated (0 vertex fetch, 1 rasterizer) |
| thresh_wr | input | 1 | Loads a new threshold |
| thresh_wdata | input | TEMP_W | Threshold value to load |
| temp_flat | input | N_UNITS*TEMP_W | Per-unit readings; unit i occupies bits [i*TEMP_W +: TEMP_W] |
| clk_en | output | 1 | Global clock enable |
| fetch_en | output | N_STAGES | Per-stage fetch enable |
| chip_scale | output | 1 | Whole chip in reduced voltage/frequency mode |
| unit_scale | output | N_UNITS | Per-unit reduced mode flags |
| resync_stall | output | 1 | Chip-wide stall while clocks resynchronize |
| throttle_cycles | output | CNT_W | Saturating count of throttled cycles |
| stall_cycles | output | CNT_W | Saturating count of stall cycles |

## Verification
The assertions check, on every cycle, that outputs stay still between boundaries, that the sample counter wraps on the boundary, that each scale-state change starts a full-length stall, and that a boundary falling inside a stall leaves the scale state frozen. They also check that only one fetch stage is gated, that clk_en is 1 after any boundary under a non-gating policy, that the chip and unit scale flags are never set together, and that the counters saturate. Some properties need a planned sequence of temperatures and policies, and only the bench scenarios show them: the strict threshold comparison at the equality point, restarting only once every unit is cool, a scale change that is held and then applied two windows later, dropping back to full speed when the policy changes, and counter totals that match the observed activity.

// File: rtl/tmc_pkg.sv
// Shared types for the thermal throttle controller.
// Assumes: policy code values are fixed by the top-level port contract.
package tmc_pkg;

    typedef enum logic [1:0] {
        POL_CLK_GATE   = 2'd0,
        POL_FETCH_GATE = 2'd1,
        POL_CHIP_SCALE = 2'd2,
        POL_UNIT_SCALE = 2'd3
    } policy_e;

endpackage

// File: rtl/tmc_sample_timer.sv
// Sample timer: produces a one-cycle strobe on every PERIOD-th clock edge
// after reset release. Assumes PERIOD >= 2.
module tmc_sample_timer #(
    parameter int unsigned PERIOD = 25000,
    localparam int unsigned TW = $clog2(PERIOD)
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe
);

    logic [TW-1:0] cnt_q;

    // Boundary is the edge at which the count sits on its last value.
    assign strobe = (cnt_q == TW'(PERIOD - 1));

    // Free-running window counter, wraps on the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (strobe) cnt_q <= '0;
        else             cnt_q <= cnt_q + TW'(1);
    end

    // R2: window restarts right after every boundary
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (cnt_q == '0));

    // R2: count never leaves the window range
    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= TW'(PERIOD - 1)));

endmodule

// File: rtl/tmc_hot_detect.sv
// Hot detector: compares each unit reading against the threshold
// (strictly greater counts as hot). Purely combinational.
// Assumes readings are unsigned whole degrees packed unit 0 in the low bits.
module tmc_hot_detect #(
    parameter int unsigned N_UNITS = 4,
    parameter int unsigned TEMP_W  = 8
) (
    input  logic [N_UNITS*TEMP_W-1:0] temp_flat,
    input  logic [TEMP_W-1:0]         thresh,
    output logic [N_UNITS-1:0]        hot,
    output logic                      any_hot
);

    // One comparator per sensor.
    for (genvar i = 0; i < N_UNITS; i++) begin : g_cmp
        assign hot[i] = (temp_flat[i*TEMP_W +: TEMP_W] > thresh);
    end

    // Any unit over threshold.
    assign any_hot = |hot;

endmodule

// File: rtl/tmc_scale_ctrl.sv
// Scale-state controller: holds the chip-wide and per-unit reduced-mode
// flags and the resynchronization stall. A change is only applied on a
// boundary with no stall running; applying it starts a RESYNC-cycle stall.
// Assumes targets are valid at the strobe edge.
module tmc_scale_ctrl #(
    parameter int unsigned N_UNITS = 4,
    parameter int unsigned RESYNC  = 3000,
    localparam int unsigned SW = $clog2(RESYNC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  logic               chip_tgt,
    input  logic [N_UNITS-1:0] unit_tgt,
    output logic               chip_scale,
    output logic [N_UNITS-1:0] unit_scale,
    output logic               stall
);

    logic               chip_q;
    logic [N_UNITS-1:0] unit_q;
    logic [SW-1:0]      stall_cnt_q;
    logic               want_change;
    logic               apply;

    // Detect a pending difference between target and current state.
    always_comb begin
        want_change = (chip_tgt != chip_q) || (unit_tgt != unit_q);
        apply       = strobe && want_change && (stall_cnt_q == '0);
    end

    // Scale state and stall countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_q      <= 1'b0;
            unit_q      <= '0;
            stall_cnt_q <= '0;
        end else if (apply) begin
            chip_q      <= chip_tgt;
            unit_q      <= unit_tgt;
            stall_cnt_q <= SW'(RESYNC);
        end else if (stall_cnt_q != '0) begin
            stall_cnt_q <= stall_cnt_q - SW'(1);
        end
    end

    assign chip_scale = chip_q;
    assign unit_scale = unit_q;
    assign stall      = (stall_cnt_q != '0);

    // R8: any scale-state change coincides with a freshly loaded stall
    p_change_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((chip_q != $past(chip_q)) || (unit_q != $past(unit_q)))
        |-> (stall_cnt_q == SW'(RESYNC)));

    // R9: a boundary inside a stall leaves the scale state untouched
    p_hold_in_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && stall) |=> ($stable(chip_q) && $stable(unit_q)));

    // R8: the countdown never exceeds its load value
    p_stall_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_cnt_q <= SW'(RESYNC)));

endmodule

// File: rtl/tmc_sat_counter.sv
// Saturating event counter: counts cycles with inc high, sticks at all ones.
// Assumes inc is a registered or otherwise glitch-free level.
module tmc_sat_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Increment until the counter is full.
    always_ff @(posedge clk) begin
        if (!rst_n)                     count <= '0;
        else if (inc && (count != '1))  count <= count + W'(1);
    end

    // R11: a full counter stays full
    p_saturate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '1) |=> (count == '1));

endmodule

// File: rtl/thermal_throttle_ctrl.sv
// Thermal throttle controller top. Samples per-unit temperatures once per
// window and, depending on the selected policy, gates the global clock,
// gates one stage's fetch, or drives chip-wide / per-unit reduced-mode
// flags with a chip-wide resynchronization stall on every scale change.
// Assumes temperatures are stable at each boundary edge and that the
// clock driving this block is not itself gated by clk_en.
module thermal_throttle_ctrl
    import tmc_pkg::*;
#(
    parameter int unsigned N_UNITS        = 4,
    parameter int unsigned TEMP_W         = 8,
    parameter int unsigned N_STAGES       = 2,
    parameter int unsigned SAMPLE_PERIOD  = 25000,
    parameter int unsigned RESYNC_CYCLES  = 3000,
    parameter int unsigned DEFAULT_THRESH = 97,
    parameter int unsigned CNT_W          = 32,
    localparam int unsigned STAGE_W = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                policy_sel,
    input  logic [STAGE_W-1:0]        fetch_stage_sel,
    input  logic                      thresh_wr,
    input  logic [TEMP_W-1:0]         thresh_wdata,
    input  logic [N_UNITS*TEMP_W-1:0] temp_flat,
    output logic                      clk_en,
    output logic [N_STAGES-1:0]       fetch_en,
    output logic                      chip_scale,
    output logic [N_UNITS-1:0]        unit_scale,
    output logic                      resync_stall,
    output logic [CNT_W-1:0]          throttle_cycles,
    output logic [CNT_W-1:0]          stall_cycles
);

    policy_e               pol;
    logic                  strobe;
    logic [TEMP_W-1:0]     thresh_q;
    logic [N_UNITS-1:0]    hot;
    logic                  any_hot;
    logic                  gate_q;
    logic [N_STAGES-1:0]   fetch_gate_q;
    logic [N_STAGES-1:0]   fetch_gate_d;
    logic                  chip_tgt;
    logic [N_UNITS-1:0]    unit_tgt;
    logic                  throttling;

    assign pol = policy_e'(policy_sel);

    // Programmable threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n)         thresh_q <= TEMP_W'(DEFAULT_THRESH);
        else if (thresh_wr) thresh_q <= thresh_wdata;
    end

    tmc_sample_timer #(.PERIOD(SAMPLE_PERIOD)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe)
    );

    tmc_hot_detect #(.N_UNITS(N_UNITS), .TEMP_W(TEMP_W)) u_hot (
        .temp_flat (temp_flat),
        .thresh    (thresh_q),
        .hot       (hot),
        .any_hot   (any_hot)
    );

    // Per-stage fetch-gate request: only the selected stage under fetch policy.
    for (genvar s = 0; s < N_STAGES; s++) begin : g_fetch
        assign fetch_gate_d[s] = (pol == POL_FETCH_GATE) && any_hot
                                 && (fetch_stage_sel == STAGE_W'(s));
    end

    // Gating decisions, registered on boundaries only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q       <= 1'b0;
            fetch_gate_q <= '0;
        end else if (strobe) begin
            gate_q       <= (pol == POL_CLK_GATE) && any_hot;
            fetch_gate_q <= fetch_gate_d;
        end
    end

    // Scale targets for the active policy; other policies target full speed.
    always_comb begin
        chip_tgt = (pol == POL_CHIP_SCALE) && any_hot;
        unit_tgt = (pol == POL_UNIT_SCALE) ? hot : '0;
    end

    tmc_scale_ctrl #(.N_UNITS(N_UNITS), .RESYNC(RESYNC_CYCLES)) u_scale (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .chip_tgt   (chip_tgt),
        .unit_tgt   (unit_tgt),
        .chip_scale (chip_scale),
        .unit_scale (unit_scale),
        .stall      (resync_stall)
    );

    assign clk_en   = ~gate_q;
    assign fetch_en = ~fetch_gate_q;

    // Any throttle in force this cycle.
    assign throttling = gate_q | (|fetch_gate_q) | chip_scale | (|unit_scale);

    tmc_sat_counter #(.W(CNT_W)) u_thr_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (throttling),
        .count (throttle_cycles)
    );

    tmc_sat_counter #(.W(CNT_W)) u_stall_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (resync_stall),
        .count (stall_cycles)
    );

    // R2: decision outputs hold between boundaries
    p_quiet_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(clk_en) && $stable(fetch_en)
                     && $stable(chip_scale) && $stable(unit_scale)));

    // R4: clock enable is restored by any boundary under a non-gating policy
    p_gate_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && (pol != POL_CLK_GATE)) |=> clk_en);

    // R5: at most one stage has its fetch disabled
    p_one_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~fetch_en));

    // R7: chip-wide and per-unit scaling never coexist
    p_scale_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_scale && (|unit_scale)));

endmodule

// File: tb/tb_thermal_throttle_ctrl.sv
`timescale 1ns/1ps
module tb_thermal_throttle_ctrl;

    localparam int P   = 40;
    localparam int RES = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  policy_sel = 2'd0;
    logic [0:0]  fetch_stage_sel = 1'b0;
    logic        thresh_wr = 1'b0;
    logic [7:0]  thresh_wdata = 8'd0;
    logic [31:0] temp_flat = '0;
    logic        clk_en;
    logic [1:0]  fetch_en;
    logic        chip_scale;
    logic [3:0]  unit_scale;
    logic        resync_stall;
    logic [31:0] throttle_cycles;
    logic [31:0] stall_cycles;

    thermal_throttle_ctrl #(
        .SAMPLE_PERIOD (P),
        .RESYNC_CYCLES (RES)
    ) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .policy_sel      (policy_sel),
        .fetch_stage_sel (fetch_stage_sel),
        .thresh_wr       (thresh_wr),
        .thresh_wdata    (thresh_wdata),
        .temp_flat       (temp_flat),
        .clk_en          (clk_en),
        .fetch_en        (fetch_en),
        .chip_scale      (chip_scale),
        .unit_scale      (unit_scale),
        .resync_stall    (resync_stall),
        .throttle_cycles (throttle_cycles),
        .stall_cycles    (stall_cycles)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        int         idx;
        logic       e_clk;
        logic [1:0] e_fetch;
        logic       e_chip;
        logic [3:0] e_unit;
        logic       e_stall;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int n_checks = 0;
    int n_err    = 0;
    int edge_n   = 0;
    int nb       = 0;
    int run_len  = 0;
    int thr_seen = 0;
    int stl_seen = 0;
    int runs     = 0;
    logic       p_clk;
    logic [1:0] p_fetch;
    logic       p_chip;
    logic [3:0] p_unit;

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Driver: apply inputs right after a boundary, queue the expectation
    // for the next boundary, then wait one window.
    task automatic step(input logic [1:0] pol, input logic stg,
                        input logic [31:0] temps, input logic wr,
                        input logic [7:0] th, input logic e_clk,
                        input logic [1:0] e_fetch, input logic e_chip,
                        input logic [3:0] e_unit, input logic e_stall,
                        input string tag);
        exp_t it;
        policy_sel      = pol;
        fetch_stage_sel = stg;
        temp_flat       = temps;
        thresh_wr       = wr;
        thresh_wdata    = th;
        nb++;
        it.idx = nb; it.e_clk = e_clk; it.e_fetch = e_fetch;
        it.e_chip = e_chip; it.e_unit = e_unit; it.e_stall = e_stall;
        it.tag = tag;
        sb_q.push_back(it);
        repeat (P) begin
            @(negedge clk);
            thresh_wr = 1'b0;
        end
    endtask

    always @(posedge clk) if (rst_n) edge_n++;

    // Monitor: compare at boundaries, check stillness elsewhere (R2),
    // measure stall runs (R8) and tally activity for the counters (R11).
    always @(negedge clk) begin
        if (rst_n && edge_n > 0) begin
            if (edge_n % P == 0) begin
                if (sb_q.size() > 0 && sb_q[0].idx == edge_n / P) begin
                    exp_t it;
                    it = sb_q.pop_front();
                    check({it.tag, " clk_en R4"}, int'(clk_en), int'(it.e_clk));
                    check({it.tag, " fetch_en R5"}, int'(fetch_en), int'(it.e_fetch));
                    check({it.tag, " chip_scale R6"}, int'(chip_scale), int'(it.e_chip));
                    check({it.tag, " unit_scale R7"}, int'(unit_scale), int'(it.e_unit));
                    check({it.tag, " resync_stall R8"}, int'(resync_stall), int'(it.e_stall));
                end
            end else begin
                check("R2 clk_en steady", int'(clk_en), int'(p_clk));
                check("R2 fetch_en steady", int'(fetch_en), int'(p_fetch));
                check("R2 chip_scale steady", int'(chip_scale), int'(p_chip));
                check("R2 unit_scale steady", int'(unit_scale), int'(p_unit));
            end
            if (resync_stall) run_len++;
            else if (run_len > 0) begin
                check("R8 stall run length", run_len, RES);
                runs++;
                run_len = 0;
            end
            if (!clk_en || fetch_en != 2'b11 || chip_scale || unit_scale != 0)
                thr_seen++;
            if (resync_stall) stl_seen++;
        end
        p_clk = clk_en; p_fetch = fetch_en; p_chip = chip_scale; p_unit = unit_scale;
    end

    initial begin
        #160000;
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", edge_n, 22 * P);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 clk_en", int'(clk_en), 1);
        check("R1 fetch_en", int'(fetch_en), 3);
        check("R1 chip_scale", int'(chip_scale), 0);
        check("R1 unit_scale", int'(unit_scale), 0);
        check("R1 resync_stall", int'(resync_stall), 0);
        check("R1 throttle_cycles", int'(throttle_cycles), 0);
        check("R1 stall_cycles", int'(stall_cycles), 0);
        rst_n = 1'b1;
        //    pol  stg temps          wr th     clk fetch chip unit  stall
        step(2'd0, 0, 32'h28282828, 0, 8'd0,  1, 2'b11, 0, 4'h0, 0, "R2 cool");
        step(2'd0, 0, 32'h28622828, 0, 8'd0,  0, 2'b11, 0, 4'h0, 0, "R3 98 hot");
        step(2'd0, 0, 32'h28612828, 0, 8'd0,  1, 2'b11, 0, 4'h0, 0, "R3 97 equal");
        step(2'd0, 0, 32'h28282878, 0, 8'd0,  0, 2'b11, 0, 4'h0, 0, "R4 hot");
        step(2'd0, 0, 32'h28282863, 0, 8'd0,  0, 2'b11, 0, 4'h0, 0, "R4 still hot");
        step(2'd0, 0, 32'h28282828, 0, 8'd0,  1, 2'b11, 0, 4'h0, 0, "R4 restart");
        step(2'd1, 0, 32'h28286428, 0, 8'd0,  1, 2'b10, 0, 4'h0, 0, "R5 vertex");
        step(2'd1, 1, 32'h28286428, 0, 8'd0,  1, 2'b01, 0, 4'h0, 0, "R5 raster");
        step(2'd1, 1, 32'h28282828, 0, 8'd0,  1, 2'b11, 0, 4'h0, 0, "R5 cool");
        step(2'd2, 0, 32'h96282828, 0, 8'd0,  1, 2'b11, 1, 4'h0, 1, "R6 enter");
        step(2'd2, 0, 32'h28282828, 0, 8'd0,  1, 2'b11, 1, 4'h0, 1, "R9 held");
        step(2'd2, 0, 32'h28282828, 0, 8'd0,  1, 2'b11, 0, 4'h0, 1, "R9 applied");
        step(2'd2, 0, 32'h28282828, 0, 8'd0,  1, 2'b11, 0, 4'h0, 1, "R6 idle");
        step(2'd3, 0, 32'h63286E28, 0, 8'd0,  1, 2'b11, 0, 4'hA, 1, "R7 two units");
        step(2'd3, 0, 32'h63286E28, 0, 8'd0,  1, 2'b11, 0, 4'hA, 1, "R7 steady");
        step(2'd3, 0, 32'h28286E28, 0, 8'd0,  1, 2'b11, 0, 4'h2, 1, "R7 one unit");
        step(2'd3, 0, 32'h28286E28, 0, 8'd0,  1, 2'b11, 0, 4'h2, 1, "R7 hold");
        step(2'd1, 0, 32'h28282828, 0, 8'd0,  1, 2'b11, 0, 4'h0, 1, "R10 leave");
        step(2'd0, 0, 32'h28282878, 1, 8'd130, 1, 2'b11, 0, 4'h0, 1, "R3 raised thr");
        step(2'd0, 0, 32'h28282883, 0, 8'd0,  0, 2'b11, 0, 4'h0, 0, "R3 over 130");
        step(2'd0, 0, 32'h28282828, 0, 8'd0,  1, 2'b11, 0, 4'h0, 0, "R4 cool");
        step(2'd0, 0, 32'h28282828, 0, 8'd0,  1, 2'b11, 0, 4'h0, 0, "R2 idle");
        @(negedge clk);
        #1;
        check("R11 throttle_cycles", int'(throttle_cycles), thr_seen);
        check("R11 stall_cycles", int'(stall_cycles), stl_seen);
        check("R11 stall total", stl_seen, 5 * RES);
        check("R8 stall runs", runs, 5);
        check("R2 queue drained", sb_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule